// File: doc/BRIEF.md
# Frequency Synthesizer Divider and Phase Detector Core

This block is the digital half of an integer-N frequency synthesizer. Every oscillator edge arrives as a one-cycle pulse on `osc_edge`, sampled in the system clock domain. A fixed prescaler turns eight such pulses (four oscillator periods) into one step, and a programmable main counter divides those steps by N to form the feedback event. Each crystal period arrives as a one-cycle pulse on `xtal_tick`, and a programmable reference counter divides those pulses by R to form the reference event. A phase/frequency detector compares the two events and drives the up and down controls of an external charge pump. The same oscillator edges also step a two-flop Johnson divider that yields in-phase and quadrature local-oscillator clocks at half the oscillator rate, with the in-phase clock a quarter period ahead.

A separate programming register supplies the parallel ratio words and a load strobe. A new ratio is held aside and is used only from the next wrap of its counter, so no divided interval is cut short. Ratios below two are raised to two. With a 1 to 4 MHz crystal, the ratios are normally picked to give a comparison rate between 50 and 250 kHz.

Top module: `pllsyn_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, `cp_up`, `cp_dn`, `lo_i`, `lo_q`, `fb_edge` and `ref_edge` are all 0 after that edge.
- R2: On each cycle with `osc_edge` high, `{lo_i,lo_q}` advances one step through 00, 10, 11, 01 and back to 00, visible after that clock edge; otherwise it holds.
- R3: `fb_edge` is a one-cycle pulse once every 8*N `osc_edge` pulses. It rises two cycles after the clock edge that samples the last pulse of the interval.
- R4: `ref_edge` is a one-cycle pulse once every R `xtal_tick` pulses. It rises one cycle after the clock edge that samples the last pulse of the interval.
- R5: `ratio_load` captures `n_ratio` and `r_ratio`. Each counter finishes its current interval with the old ratio and uses the new one from its next wrap. A strobe in the same cycle as a wrap takes effect one wrap later.
- R6: A loaded or default ratio of 0 or 1 is used as 2.
- R7: After reset the ratios are N=`DEF_N` and R=`DEF_R`.
- R8: `cp_up` goes high the cycle after `ref_edge`, and `cp_dn` goes high the cycle after `fb_edge`. Each then stays high until both are high.
- R9: When `cp_up` and `cp_dn` are both high, both are high for exactly one cycle and then both are 0. A divided event that arrives during that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_edge | input | 1 | One pulse per oscillator edge (half period) |
| xtal_tick | input | 1 | One pulse per crystal period |
| ratio_load | input | 1 | Load strobe for both ratio words |
| n_ratio | input | N_W (12) | Main divider ratio |
| r_ratio | input | R_W (8) | Reference divider ratio |
| cp_up | output | 1 | Charge pump up control |
| cp_dn | output | 1 | Charge pump down control |
| lo_i | output | 1 | In-phase half-rate clock |
| lo_q | output | 1 | Quadrature half-rate clock |
| fb_edge | output | 1 | Divided feedback event |
| ref_edge | output | 1 | Divided reference event |

## Verification
A wrong prescaler phase or counter value moves `fb_edge` or `ref_edge` off its expected cycle at the first wrap that follows, which is within 8*N oscillator pulses or R crystal ticks. One cycle after that, the wrong event also shows on `cp_dn` or `cp_up`. A ratio applied too early shortens the interval that is already running, so the error appears before the next wrap. A quadrature flop that is out of step breaks the 00-10-11-01 order on the very next `osc_edge`. The bench compares every output to a behavioural model on every cycle, so each of these faults is reported on the cycle it first appears.

// File: rtl/pllsyn_pkg.sv
// Shared constants and types for the synthesizer digital core.
package pllsyn_pkg;
    // Smallest divide ratio either counter will use.
    localparam int MIN_RATIO = 2;

    // Phase detector state: bit 0 = up pending, bit 1 = down pending.
    typedef enum logic [1:0] {
        PFD_IDLE = 2'b00,
        PFD_UP   = 2'b01,
        PFD_DN   = 2'b10,
        PFD_BOTH = 2'b11
    } pfd_state_e;
endpackage

// File: rtl/pllsyn_quad.sv
// Half-rate quadrature generator.
// Two flops form a Johnson ring that advances on every oscillator edge
// pulse, so I leads Q by one oscillator half period (a quarter of the
// output period). Assumes osc_edge is a one-cycle pulse per edge.
module pllsyn_quad (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_edge,
    output logic lo_i,
    output logic lo_q
);
    // Johnson ring step: I takes not-Q, Q takes I.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_i <= 1'b0;
            lo_q <= 1'b0;
        end else if (osc_edge) begin
            lo_i <= ~lo_q;
            lo_q <= lo_i;
        end
    end

    // R2: Q follows I by one step
    p_quad_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        osc_edge |=> (lo_q == $past(lo_i)));
    // R2: no step without an edge pulse
    p_quad_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_edge |=> $stable({lo_i, lo_q}));
endmodule

// File: rtl/pllsyn_prescale.sv
// Fixed feedback prescaler.
// Counts oscillator edge pulses and emits one registered step for every
// PRE_DIV oscillator periods (2*PRE_DIV edge pulses).
module pllsyn_prescale #(
    parameter int PRE_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_edge,
    output logic pre_step
);
    localparam int PRE_HALF = 2 * PRE_DIV;
    localparam int PC_W     = $clog2(PRE_HALF);
    localparam logic [PC_W-1:0] LAST = PC_W'(PRE_HALF - 1);

    logic [PC_W-1:0] cnt;

    // Edge counter with wrap and registered step output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            pre_step <= 1'b0;
        end else begin
            pre_step <= osc_edge && (cnt == LAST);
            if (osc_edge) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // R3: a step is always followed by a quiet cycle
    p_step_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pre_step |=> !pre_step);
endmodule

// File: rtl/pllsyn_div.sv
// Programmable divide-by-ratio counter with deferred reload.
// Counts step pulses and emits a one-cycle terminal pulse every `act`
// steps. A loaded ratio is kept aside and becomes active only at the
// next wrap. Ratios below MIN_RATIO are raised to MIN_RATIO.
module pllsyn_div #(
    parameter int W   = 12,
    parameter int DEF = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         load,
    input  logic [W-1:0] word,
    output logic         tc
);
    localparam logic [W-1:0] MINV  = W'(pllsyn_pkg::MIN_RATIO);
    localparam logic [W-1:0] DEF_V = (DEF < pllsyn_pkg::MIN_RATIO) ? MINV : W'(DEF);

    logic [W-1:0] act;
    logic [W-1:0] shadow;
    logic         armed;
    logic [W-1:0] cnt;
    logic [W-1:0] word_c;
    logic         wrap;

    // Floor the incoming ratio.
    always_comb word_c = (word < MINV) ? MINV : word;
    // Wrap happens on a step while the count sits at zero.
    always_comb wrap = step && (cnt == '0);

    // Count down, reload at wrap, capture and arm on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act    <= DEF_V;
            shadow <= DEF_V;
            armed  <= 1'b0;
            cnt    <= DEF_V - 1'b1;
            tc     <= 1'b0;
        end else begin
            tc <= wrap;
            if (wrap) begin
                if (armed) begin
                    act   <= shadow;
                    cnt   <= shadow - 1'b1;
                    armed <= 1'b0;
                end else begin
                    cnt <= act - 1'b1;
                end
            end else if (step) begin
                cnt <= cnt - 1'b1;
            end
            if (load) begin
                shadow <= word_c;
                armed  <= 1'b1;
            end
        end
    end

    // R6: active ratio never below the floor
    p_act_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        act >= MINV);
    // R5: active ratio only changes at a wrap
    p_act_at_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(act));
    // R4: terminal output is a single-cycle pulse
    p_tc_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc);
endmodule

// File: rtl/pllsyn_pfd.sv
// Phase/frequency detector.
// Latches up on a reference event and down on a feedback event. When
// both are latched they stay high together for one cycle and then both
// clear. Events that arrive during the clearing cycle are dropped.
module pllsyn_pfd (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_ev,
    input  logic fb_ev,
    output logic cp_up,
    output logic cp_dn
);
    import pllsyn_pkg::*;

    pfd_state_e st;

    // State update: set on events, clear one cycle after both are set.
    always_ff @(posedge clk) begin
        if (!rst_n)               st <= PFD_IDLE;
        else if (st == PFD_BOTH)  st <= PFD_IDLE;
        else                      st <= pfd_state_e'(st | {fb_ev, ref_ev});
    end

    // Decode the pump controls from the state bits.
    always_comb begin
        cp_up = st[0];
        cp_dn = st[1];
    end

    // R9: coincident pulses clear after one cycle
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_up && cp_dn) |=> (!cp_up && !cp_dn));
    // R8: reference event raises up
    p_up_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_ev && !(cp_up && cp_dn)) |=> cp_up);
    // R8: feedback event raises down
    p_dn_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_ev && !(cp_up && cp_dn)) |=> cp_dn);
endmodule

// File: rtl/pllsyn_core.sv
// Synthesizer digital core top.
// Feedback path: oscillator edges -> fixed prescaler -> main counter.
// Reference path: crystal ticks -> reference counter. Both divided events
// drive the phase/frequency detector. Oscillator edges also drive the
// quadrature generator. All inputs are single-cycle pulses that are
// synchronous to clk.
module pllsyn_core #(
    parameter int N_W     = 12,
    parameter int R_W     = 8,
    parameter int PRE_DIV = 4,
    parameter int DEF_N   = 3,
    parameter int DEF_R   = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           osc_edge,
    input  logic           xtal_tick,
    input  logic           ratio_load,
    input  logic [N_W-1:0] n_ratio,
    input  logic [R_W-1:0] r_ratio,
    output logic           cp_up,
    output logic           cp_dn,
    output logic           lo_i,
    output logic           lo_q,
    output logic           fb_edge,
    output logic           ref_edge
);
    logic pre_step;

    pllsyn_quad u_quad (
        .clk(clk), .rst_n(rst_n), .osc_edge(osc_edge),
        .lo_i(lo_i), .lo_q(lo_q)
    );

    pllsyn_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .osc_edge(osc_edge), .pre_step(pre_step)
    );

    pllsyn_div #(.W(N_W), .DEF(DEF_N)) u_ndiv (
        .clk(clk), .rst_n(rst_n), .step(pre_step), .load(ratio_load),
        .word(n_ratio), .tc(fb_edge)
    );

    pllsyn_div #(.W(R_W), .DEF(DEF_R)) u_rdiv (
        .clk(clk), .rst_n(rst_n), .step(xtal_tick), .load(ratio_load),
        .word(r_ratio), .tc(ref_edge)
    );

    pllsyn_pfd u_pfd (
        .clk(clk), .rst_n(rst_n), .ref_ev(ref_edge), .fb_ev(fb_edge),
        .cp_up(cp_up), .cp_dn(cp_dn)
    );

    // R3: feedback event needs a prescaler step before it
    p_fb_after_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fb_edge |-> $past(pre_step));
endmodule

// File: tb/pllsyn_core_bench.sv
module pllsyn_core_bench;
    localparam int DEF_N = 3;
    localparam int DEF_R = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_edge = 1'b0;
    logic        xtal_tick = 1'b0;
    logic        ratio_load = 1'b0;
    logic [11:0] n_ratio = '0;
    logic [7:0]  r_ratio = '0;
    logic cp_up, cp_dn, lo_i, lo_q, fb_edge, ref_edge;

    int checks = 0;
    int bad = 0;
    int cyc = 0;
    bit cmp_on = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pllsyn_core #(.DEF_N(DEF_N), .DEF_R(DEF_R)) u_pllsyn_core (
        .clk(clk), .rst_n(rst_n), .osc_edge(osc_edge), .xtal_tick(xtal_tick),
        .ratio_load(ratio_load), .n_ratio(n_ratio), .r_ratio(r_ratio),
        .cp_up(cp_up), .cp_dn(cp_dn), .lo_i(lo_i), .lo_q(lo_q),
        .fb_edge(fb_edge), .ref_edge(ref_edge)
    );

    // Behavioural reference model
    int ph, pc, fpos, fper, fsh, rpos, rper, rsh;
    bit ptk, farm, rarm, m_fe, m_re, m_up, m_dn;

    function automatic int floor2(int v);
        return (v < 2) ? 2 : v;
    endfunction

    always @(posedge clk) begin
        bit n_fe, n_re, n_up, n_dn, n_ptk;
        if (!rst_n) begin
            ph = 0; pc = 0; ptk = 0;
            fpos = 0; fper = floor2(DEF_N); fsh = fper; farm = 0;
            rpos = 0; rper = floor2(DEF_R); rsh = rper; rarm = 0;
            m_fe = 0; m_re = 0; m_up = 0; m_dn = 0;
        end else begin
            if (m_up && m_dn) begin n_up = 0; n_dn = 0; end
            else begin n_up = m_up | m_re; n_dn = m_dn | m_fe; end
            n_fe = ptk && (fpos + 1 == fper);
            if (ptk) begin
                if (n_fe) begin fpos = 0; if (farm) begin fper = fsh; farm = 0; end end
                else fpos++;
            end
            n_re = xtal_tick && (rpos + 1 == rper);
            if (xtal_tick) begin
                if (n_re) begin rpos = 0; if (rarm) begin rper = rsh; rarm = 0; end end
                else rpos++;
            end
            if (ratio_load) begin
                fsh = floor2(int'(n_ratio)); farm = 1;
                rsh = floor2(int'(r_ratio)); rarm = 1;
            end
            n_ptk = osc_edge && (pc == 7);
            if (osc_edge) begin pc = (pc + 1) % 8; ph = (ph + 1) % 4; end
            ptk = n_ptk; m_fe = n_fe; m_re = n_re; m_up = n_up; m_dn = n_dn;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s cycle %0d actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    // Per-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check(lo_i == (ph == 1 || ph == 2), "R2 lo_i", lo_i, (ph == 1 || ph == 2));
            check(lo_q == (ph == 2 || ph == 3), "R2 lo_q", lo_q, (ph == 2 || ph == 3));
            check(fb_edge == m_fe, "R3/R5 fb_edge", fb_edge, m_fe);
            check(ref_edge == m_re, "R4/R5 ref_edge", ref_edge, m_re);
            check(cp_up == m_up, "R8/R9 cp_up", cp_up, m_up);
            check(cp_dn == m_dn, "R8/R9 cp_dn", cp_dn, m_dn);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            bad++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    logic [15:0] lfsr = 16'hACE1;
    task automatic run(input int n, input int osc_mode, input int xt_mode);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            osc_edge  = (osc_mode == 0) ? 1'b1 : (osc_mode == 1) ? lfsr[0] : (i % 3 == 0);
            xtal_tick = (xt_mode == 0) ? 1'b1 : (xt_mode == 1) ? lfsr[5] : (i % 7 == 0);
            ratio_load = 1'b0;
        end
    endtask

    task automatic load(input int n, input int r);
        @(negedge clk);
        n_ratio = 12'(n); r_ratio = 8'(r); ratio_load = 1'b1;
        osc_edge = 1'b1; xtal_tick = 1'b1;
        @(negedge clk);
        ratio_load = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check({cp_up, cp_dn, lo_i, lo_q, fb_edge, ref_edge} == 6'b0, "R1 reset outputs",
              {cp_up, cp_dn, lo_i, lo_q, fb_edge, ref_edge}, 0);
        rst_n = 1'b1;
        cmp_on = 1;
        // R7 default ratios, R2/R3/R4 under several input patterns
        run(2000, 0, 2);
        run(2000, 1, 1);
        run(2000, 2, 0);
        // R5: mid-interval loads
        load(5, 4);
        run(3000, 1, 1);
        load(7, 9);
        run(20, 0, 0);
        load(2, 3);
        run(3000, 0, 1);
        // R6: clamp of 0 and 1
        load(0, 1);
        run(3000, 1, 0);
        // R6: reference interval with every-cycle ticks must be 2
        begin
            int gap = 0;
            @(negedge clk);
            while (!ref_edge) @(negedge clk);
            @(negedge clk); gap = 1;
            while (!ref_edge && gap < 20) begin @(negedge clk); gap++; end
            check(gap == 2, "R6 clamped reference gap", gap, 2);
        end
        load(1, 0);
        run(3000, 0, 0);
        // R9: near-equal rates force frequent coincidences
        load(1, 16);
        run(4000, 0, 0);
        // R1 again: mid-run reset
        @(negedge clk); rst_n = 1'b0; cmp_on = 0;
        @(negedge clk); @(negedge clk);
        check({cp_up, cp_dn, lo_i, lo_q, fb_edge, ref_edge} == 6'b0, "R1 reset mid-run",
              {cp_up, cp_dn, lo_i, lo_q, fb_edge, ref_edge}, 0);
        rst_n = 1'b1; cmp_on = 1;
        // R7: defaults restored after reset
        run(2000, 0, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule